// File: doc/BRIEF.md
# Display Origin and Dot-Rate Timing Controller

This block places an on-screen overlay on a monitor picture by timing it against the incoming horizontal and vertical sync pulses. After each vertical sync it counts horizontal lines until the programmed vertical origin. After each horizontal sync it divides the system clock into dots and counts them until the programmed horizontal origin. Inside the resulting rectangle it raises a display enable, a strobe on the last system clock of every dot, and a column strobe every ten dots, which is one font cell. It also reports the index of the current character column.

The vertical origin is set in steps of four lines and the horizontal origin in steps of five dots. A line carries 320, 480 or 640 dots, and the choice of resolution sets how many system clocks make one dot. The origin and resolution inputs are sampled once per frame, on the vertical sync edge, so the picture never tears in the middle of a frame. A master enable gates every output. A fast-blank output tells the video mixer when the overlay owns the pixel: either whenever characters or window backgrounds are shown, or only when characters are shown. Font lookup and window colouring sit outside this block and report their activity through two input flags.

Top module: `osd_origin_timer`

## Requirements
- R1: Until the first vertical sync edge after reset, the block uses a vertical origin value of 4 (line 16), a horizontal origin value of 15 (dot 75) and 320 dots per line, whatever the inputs hold.
- R2: A vertical sync rising edge does three things. It captures `vstart`, `hstart`, `res_x64` and `res_x32b`, and changes to those inputs at any other time have no effect. It resets the line number to 0. It restarts dot timing exactly as a horizontal sync edge does.
- R3: The line number is the count of horizontal sync rising edges since the last vertical sync edge, or since reset. A line lies inside the vertical region when its number is at least 4 × the captured vertical origin.
- R4: The dot index is floor(n / d). Here n is the number of clocks since the clock that sampled the last horizontal or vertical sync rising edge, and d is the number of clocks per dot. A dot lies inside the horizontal region when 5 × the captured horizontal origin ≤ dot index < dots per line.
- R5: An origin value of zero, for either axis, behaves exactly like an origin value of 1.
- R6: The clocks per dot follow `{res_x64,res_x32b}`. With `res_x32b`=0, the line has 320 dots at 2×BASE_DIV clocks each, and `res_x64` is ignored. The value 01 gives 480 dots at 4×BASE_DIV/3 clocks each. The value 11 gives 640 dots at BASE_DIV clocks each.
- R7: `disp_en` is high exactly when `osd_en` is high and both the vertical and the horizontal region hold. With `osd_en` low, every output is 0. During reset, every output is 0.
- R8: `dot_stb` is high on the last clock of each dot, that is when n mod d = d−1, and only while `disp_en` is high.
- R9: With r = dot index − 5 × horizontal origin, `col_idx` equals r/10 while `disp_en` is high and 0 otherwise. `col_stb` is high on the `dot_stb` clock of every dot where r mod 10 = 9.
- R10: With `fb_sel`=0, `fast_blank` = `disp_en` AND (`char_on` OR `win_on`). With `fb_sel`=1, `fast_blank` = `disp_en` AND `char_on`.
- R11: Sync inputs are active-high. Only a rising edge counts, so holding a sync input high for several clocks acts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync, active-high |
| vsync | input | 1 | Vertical sync, active-high |
| osd_en | input | 1 | Master overlay enable |
| vstart | input | 8 | Vertical origin in 4-line steps |
| hstart | input | 7 | Horizontal origin in 5-dot steps |
| res_x64 | input | 1 | Resolution select, high bit |
| res_x32b | input | 1 | Resolution select, low bit |
| fb_sel | input | 1 | Fast-blank meaning: 0 = characters or windows, 1 = characters only |
| char_on | input | 1 | Character pixel active, from the font logic |
| win_on | input | 1 | Window background active, from the window logic |
| disp_en | output | 1 | Inside the display rectangle |
| dot_stb | output | 1 | Last clock of a displayed dot |
| col_stb | output | 1 | Last clock of a character column |
| col_idx | output | 7 | Current character column |
| fast_blank | output | 1 | Fast-blank to the video mixer |

## Verification
The bench builds the block with its default parameters. BASE_DIV = 3 gives 6, 4 and 3 clocks per dot, so every resolution ends its line at 1920 clocks. A 2000-clock line therefore runs past the last dot in all three modes, and the right-hand region boundary is exercised in each. Shorter random lines and vertical origins of 0 to 3 keep each frame a few thousand clocks long. That leaves room for the reset defaults, the zero-origin case and several random frames, with sync pulses held high for one to four clocks.

// File: rtl/osd_org_pkg.sv
package osd_org_pkg;

  typedef enum logic [1:0] {
    RES_320 = 2'd0,
    RES_480 = 2'd1,
    RES_640 = 2'd2
  } res_e;

  localparam int unsigned MAX_DOTS = 640;

  // x32b clear always means the low resolution; x64 then picks the upper two
  function automatic res_e res_decode(input logic sel_hi, input logic sel_lo);
    if (!sel_lo) return RES_320;
    if (sel_hi) return RES_640;
    return RES_480;
  endfunction

  function automatic int unsigned res_dots(input res_e r);
    case (r)
      RES_480: return 480;
      RES_640: return 640;
      default: return 320;
    endcase
  endfunction

  // clocks per dot, scaled so every mode spans the same line period
  function automatic int unsigned res_clks(input res_e r, input int unsigned base);
    case (r)
      RES_640: return base;
      RES_480: return (base * 4) / 3;
      default: return base * 2;
    endcase
  endfunction

  function automatic int unsigned lift_zero(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  output logic hs_rise,
  output logic vs_rise
);

  logic hs_q;
  logic vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
    end
  end

  assign hs_rise = hsync & ~hs_q;
  assign vs_rise = vsync & ~vs_q;

  assert_hs_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> !hs_rise);
  assert_vs_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> !vs_rise);

endmodule

// File: rtl/osd_frame_cfg.sv
module osd_frame_cfg
  import osd_org_pkg::*;
#(
  parameter int VSTART_W   = 8,
  parameter int HSTART_W   = 7,
  parameter int V_STEP     = 4,
  parameter int H_STEP     = 5,
  parameter int VSTART_RST = 4,
  parameter int HSTART_RST = 15,
  parameter int LINE_W     = 11,
  parameter int DOT_W      = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [VSTART_W-1:0] vstart,
  input  logic [HSTART_W-1:0] hstart,
  input  logic                sel_hi,
  input  logic                sel_lo,
  output logic [LINE_W-1:0]   first_line,
  output logic [DOT_W-1:0]    first_dot,
  output res_e                res
);

  localparam logic [LINE_W-1:0] LINE_RST = LINE_W'(lift_zero(VSTART_RST) * V_STEP);
  localparam logic [DOT_W-1:0]  DOT_RST  = DOT_W'(lift_zero(HSTART_RST) * H_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_line <= LINE_RST;
      first_dot  <= DOT_RST;
      res        <= RES_320;
    end else if (capture) begin
      first_line <= LINE_W'(lift_zero(32'(vstart)) * V_STEP);
      first_dot  <= DOT_W'(lift_zero(32'(hstart)) * H_STEP);
      res        <= res_decode(sel_hi, sel_lo);
    end
  end

  assert_origin_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (first_line != '0) && (first_dot != '0));
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(first_line) && $stable(first_dot) && $stable(res)));
  assert_res_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res != 2'd3);

endmodule

// File: rtl/osd_line_tracker.sv
module osd_line_tracker #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise,
  input  logic              vs_rise,
  input  logic [LINE_W-1:0] first_line,
  output logic              v_act
);

  localparam logic [LINE_W-1:0] LINE_TOP = '1;

  logic [LINE_W-1:0] line_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
    end else if (vs_rise) begin
      line_cnt <= '0;
    end else if (hs_rise && (line_cnt != LINE_TOP)) begin
      line_cnt <= line_cnt + 1'b1;
    end
  end

  assign v_act = (line_cnt >= first_line);

  assert_line_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_cnt == '0));
  assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vs_rise && (line_cnt != LINE_TOP)) |=> (line_cnt == $past(line_cnt) + 1'b1));
  assert_line_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_rise && !vs_rise) |=> $stable(line_cnt));

endmodule

// File: rtl/osd_dot_tracker.sv
module osd_dot_tracker #(
  parameter int CLK_W  = 3,
  parameter int DOT_W  = 11,
  parameter int COL_W  = 7,
  parameter int FONT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CLK_W-1:0] div,
  input  logic [DOT_W-1:0] dots_line,
  input  logic [DOT_W-1:0] first_dot,
  output logic             tick,
  output logic             h_act,
  output logic             col_last,
  output logic [COL_W-1:0] col_q
);

  localparam int FD_W = $clog2(FONT_W);
  localparam logic [DOT_W-1:0] DOT_TOP  = '1;
  localparam logic [FD_W-1:0]  FD_LAST  = FD_W'(FONT_W - 1);

  logic [CLK_W-1:0] clk_cnt;
  logic [DOT_W-1:0] dot_cnt;
  logic [DOT_W-1:0] dot_next;
  logic [FD_W-1:0]  col_dot;

  assign tick     = (clk_cnt == div - 1'b1);
  assign dot_next = dot_cnt + 1'b1;
  assign h_act    = (dot_cnt >= first_dot) && (dot_cnt < dots_line);
  assign col_last = (col_dot == FD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cnt <= '0;
      dot_cnt <= '0;
      col_dot <= '0;
      col_q   <= '0;
    end else if (restart) begin
      clk_cnt <= '0;
      dot_cnt <= '0;
      col_dot <= '0;
      col_q   <= '0;
    end else if (tick) begin
      clk_cnt <= '0;
      if (dot_cnt != DOT_TOP) dot_cnt <= dot_next;
      if (dot_next == first_dot) begin
        col_dot <= '0;
        col_q   <= '0;
      end else if (h_act) begin
        if (col_last) begin
          col_dot <= '0;
          col_q   <= col_q + 1'b1;
        end else begin
          col_dot <= col_dot + 1'b1;
        end
      end
    end else begin
      clk_cnt <= clk_cnt + 1'b1;
    end
  end

  assert_dot_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ((dot_cnt == '0) && (clk_cnt == '0)));
  assert_phase_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_cnt < div);
  assert_dot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(dot_cnt));
  assert_col_in_cell_R9: assert property (@(posedge clk) disable iff (!rst_n)
    col_dot <= FD_LAST);

endmodule

// File: rtl/osd_origin_timer.sv
module osd_origin_timer
  import osd_org_pkg::*;
#(
  parameter int BASE_DIV   = 3,
  parameter int VSTART_W   = 8,
  parameter int HSTART_W   = 7,
  parameter int V_STEP     = 4,
  parameter int H_STEP     = 5,
  parameter int FONT_W     = 10,
  parameter int VSTART_RST = 4,
  parameter int HSTART_RST = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hsync,
  input  logic                vsync,
  input  logic                osd_en,
  input  logic [VSTART_W-1:0] vstart,
  input  logic [HSTART_W-1:0] hstart,
  input  logic                res_x64,
  input  logic                res_x32b,
  input  logic                fb_sel,
  input  logic                char_on,
  input  logic                win_on,
  output logic                disp_en,
  output logic                dot_stb,
  output logic                col_stb,
  output logic [$clog2(osd_org_pkg::MAX_DOTS/FONT_W)+1-1:0] col_idx,
  output logic                fast_blank
);

  localparam int LINE_W = $clog2(((2 ** VSTART_W) - 1) * V_STEP + 1) + 1;
  localparam int DOT_W  = $clog2(MAX_DOTS + 1) + 1;
  localparam int COL_W  = $clog2(MAX_DOTS / FONT_W) + 1;
  localparam int CLK_W  = $clog2(2 * BASE_DIV + 1);

  logic              hs_rise;
  logic              vs_rise;
  logic [LINE_W-1:0] first_line;
  logic [DOT_W-1:0]  first_dot;
  res_e              res;
  logic [CLK_W-1:0]  div;
  logic [DOT_W-1:0]  dots_line;
  logic              v_act;
  logic              h_act;
  logic              tick;
  logic              col_last;
  logic [COL_W-1:0]  col_q;

  osd_sync_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync   (hsync),
    .vsync   (vsync),
    .hs_rise (hs_rise),
    .vs_rise (vs_rise)
  );

  osd_frame_cfg #(
    .VSTART_W   (VSTART_W),
    .HSTART_W   (HSTART_W),
    .V_STEP     (V_STEP),
    .H_STEP     (H_STEP),
    .VSTART_RST (VSTART_RST),
    .HSTART_RST (HSTART_RST),
    .LINE_W     (LINE_W),
    .DOT_W      (DOT_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (vs_rise),
    .vstart     (vstart),
    .hstart     (hstart),
    .sel_hi     (res_x64),
    .sel_lo     (res_x32b),
    .first_line (first_line),
    .first_dot  (first_dot),
    .res        (res)
  );

  assign div       = CLK_W'(res_clks(res, BASE_DIV));
  assign dots_line = DOT_W'(res_dots(res));

  osd_line_tracker #(
    .LINE_W (LINE_W)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_rise    (hs_rise),
    .vs_rise    (vs_rise),
    .first_line (first_line),
    .v_act      (v_act)
  );

  osd_dot_tracker #(
    .CLK_W  (CLK_W),
    .DOT_W  (DOT_W),
    .COL_W  (COL_W),
    .FONT_W (FONT_W)
  ) u_dot (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (hs_rise | vs_rise),
    .div       (div),
    .dots_line (dots_line),
    .first_dot (first_dot),
    .tick      (tick),
    .h_act     (h_act),
    .col_last  (col_last),
    .col_q     (col_q)
  );

  assign disp_en    = osd_en & v_act & h_act;
  assign dot_stb    = disp_en & tick;
  assign col_stb    = dot_stb & col_last;
  assign col_idx    = disp_en ? col_q : '0;
  assign fast_blank = disp_en & (char_on | (~fb_sel & win_on));

  assert_master_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !osd_en |-> (!disp_en && !dot_stb && !fast_blank && (col_idx == '0)));
  assert_col_on_dot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb |-> dot_stb);
  assert_blank_inside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fast_blank |-> disp_en);
  assert_dot_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_stb && (div != 1) && !vs_rise && !hs_rise) |=> !dot_stb);

endmodule

// File: tb/test_osd_origin_timer.sv
module test_osd_origin_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0, vsync = 1'b0, osd_en = 1'b0;
  logic       res_x64 = 1'b0, res_x32b = 1'b0, fb_sel = 1'b0;
  logic       char_on = 1'b0, win_on = 1'b0;
  logic [7:0] vstart = 8'd0;
  logic [6:0] hstart = 7'd0;
  logic       disp_en, dot_stb, col_stb, fast_blank;
  logic [6:0] col_idx;

  int    checks = 0;
  int    errors = 0;
  int    en_seen = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string phase = "reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_origin_timer i_osd_origin_timer (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .osd_en(osd_en),
    .vstart(vstart), .hstart(hstart), .res_x64(res_x64), .res_x32b(res_x32b),
    .fb_sel(fb_sel), .char_on(char_on), .win_on(win_on),
    .disp_en(disp_en), .dot_stb(dot_stb), .col_stb(col_stb),
    .col_idx(col_idx), .fast_blank(fast_blank)
  );

  function automatic int b_div(bit w, bit e);
    if (!e) return 6;
    return w ? 3 : 4;
  endfunction

  function automatic int b_dots(bit w, bit e);
    if (!e) return 320;
    return w ? 640 : 480;
  endfunction

  function automatic int b_lift(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual %0d expected %0d", what, phase, act, exp);
    end
  endtask

  // reference state: raw clock count since sync edge, edges counted since vsync
  bit m_hs, m_vs, m_w, m_e;
  int m_n, m_line, m_v, m_h;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hs <= 0; m_vs <= 0; m_n <= 0; m_line <= 0;
      m_v <= 4; m_h <= 15; m_w <= 0; m_e <= 0;
    end else begin
      m_hs <= hsync;
      m_vs <= vsync;
      if (vsync && !m_vs) begin
        m_line <= 0; m_n <= 0;
        m_v <= b_lift(int'(vstart)); m_h <= b_lift(int'(hstart));
        m_w <= res_x64; m_e <= res_x32b;
      end else if (hsync && !m_hs) begin
        m_line <= m_line + 1; m_n <= 0;
      end else begin
        m_n <= m_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int dv, dt, h0, rel;
      bit en, last;
      dv   = b_div(m_w, m_e);
      dt   = m_n / dv;
      h0   = 5 * m_h;
      en   = osd_en && (m_line >= 4 * m_v) && (dt >= h0) && (dt < b_dots(m_w, m_e));
      rel  = dt - h0;
      last = ((m_n % dv) == dv - 1);
      chk(disp_en === en, "R3 R4 R7 disp_en", int'(disp_en), int'(en));
      chk(dot_stb === (en && last), "R6 R8 dot_stb", int'(dot_stb), int'(en && last));
      chk(col_stb === (en && last && (rel % 10 == 9)), "R9 col_stb",
          int'(col_stb), int'(en && last && (rel % 10 == 9)));
      chk(int'(col_idx) == (en ? rel / 10 : 0), "R9 col_idx", int'(col_idx), en ? rel / 10 : 0);
      chk(fast_blank === (en && (char_on || (!fb_sel && win_on))), "R10 fast_blank",
          int'(fast_blank), int'(en && (char_on || (!fb_sel && win_on))));
      if (en) en_seen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual %0d expected below %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // R11: sync held 1..4 clocks per pulse
  task automatic run_line(int len, bit with_vs, bit en_line);
    int hold;
    hold = $urandom_range(1, 4);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      hsync   = (i < hold);
      vsync   = with_vs && (i < hold);
      osd_en  = en_line;
      char_on = 1'($urandom_range(0, 1));
      win_on  = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic run_frame(int vs, int hs, bit w, bit e, bit fb, string tag);
    int nl, seen0;
    vstart = 8'(vs); hstart = 7'(hs); res_x64 = w; res_x32b = e; fb_sel = fb;
    phase = tag;
    nl = 4 * b_lift(vs) + 3;
    seen0 = en_seen;
    run_line($urandom_range(120, 500), 1'b1, 1'b1);
    // R2: register inputs move after capture and must not matter
    vstart = 8'($urandom); hstart = 7'($urandom);
    res_x64 = 1'($urandom_range(0, 1)); res_x32b = 1'($urandom_range(0, 1));
    for (int l = 1; l < nl; l++) begin
      if (l >= nl - 2) run_line(2000, 1'b0, 1'b1);
      else run_line($urandom_range(120, 500), 1'b0, $urandom_range(0, 4) != 0);
    end
    chk(en_seen > seen0, {tag, " region reached"}, en_seen - seen0, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    vstart = 8'd200; hstart = 7'd100; res_x64 = 1'b1; res_x32b = 1'b1; osd_en = 1'b1;
    char_on = 1'b1; win_on = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(disp_en === 1'b0, "R7 reset disp_en", int'(disp_en), 0);
    chk(dot_stb === 1'b0, "R7 reset dot_stb", int'(dot_stb), 0);
    chk(col_stb === 1'b0, "R7 reset col_stb", int'(col_stb), 0);
    chk(col_idx === 7'd0, "R7 reset col_idx", int'(col_idx), 0);
    chk(fast_blank === 1'b0, "R7 reset fast_blank", int'(fast_blank), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1: no vsync yet, inputs hold values that must be ignored
    phase = "R1 defaults";
    for (int l = 0; l < 19; l++)
      run_line((l >= 17) ? 2000 : $urandom_range(120, 400), 1'b0, 1'b1);
    chk(en_seen > 0, "R1 region reached", en_seen, 1);

    run_frame(2, 3, 1'b1, 1'b1, 1'b0, "R6 640 dots");
    run_frame(1, 10, 1'b0, 1'b1, 1'b1, "R6 480 dots");
    run_frame(0, 0, 1'b0, 1'b0, 1'b0, "R5 zero origins");
    run_frame(1, 5, 1'b1, 1'b0, 1'b1, "R6 x64 ignored at 320");
    run_frame(3, 1, 1'b1, 1'b1, 1'b1, "R2 R11 deep origin");
    for (int f = 0; f < 3; f++)
      run_frame($urandom_range(1, 3), $urandom_range(1, 30),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), "R3 R4 random frame");

    // R7: master enable off for whole lines
    phase = "R7 master off";
    osd_en = 1'b0;
    for (int l = 0; l < 3; l++) run_line(2000, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule